// File: doc/BRIEF.md
# Masked Prioritized Error Manager

The block gathers many single-bit error lines arranged into classes, one group of up to ten member lines per class, each class with its own 32-bit payload word. Each class is reduced to a single flag, the OR of its members. A configuration register enables handling globally and per class. Whenever the flag of an enabled class changes state, the block issues one report: a one-hot class code, a 10-bit detail word that priority-encodes the members, the 32-bit payload and a status byte.

The configuration register is deliberately left outside the reset domain. It holds its contents through any number of block resets, so software programs it once. Reports come out one per cycle as a registered strobe. When several classes are waiting, the class with the lowest code bit goes first. A class whose flag drops is reported once more with an all-zero detail to announce that the error has gone.

Top module: `em_error_manager`

## Requirements
- R1: The configuration register is written when `reg_we` is high and `reg_addr` equals 0xF0. `reg_rdata` returns, one cycle after `reg_addr` is presented, the full 32-bit stored value, including the unused upper bits exactly as written. Any other address reads 0, and a write to another address changes nothing.
- R2: `rst` has no effect on the configuration register. Its value after a reset equals its value before.
- R3: With configuration bit 0 at 0, no report is produced whatever the error inputs do.
- R4: Configuration bit k+1 enables class k (class k has code 1<<k). A disabled class produces no reports and does not delay reports of enabled classes.
- R5: A class flag is the OR of its member lines. When the flag of an enabled class rises, exactly one report with code 1<<k appears on the clock edge after the input change. A flag that stays high, even while its members change, produces no further report.
- R6: When several enabled classes are waiting at once, they are reported one per cycle in increasing code-bit order.
- R7: In the detail word, only the highest-indexed active member is set (one-hot). For example, class 3 (three trigger-control machines, members bit2=L0, bit1=L1, bit0=L2) with members 0b011 reports 0x002.
- R8: For the six link-receiver classes (code bits 7 to 12), detail bit 9 is always set. Bit 9 is accompanied by the highest active member among bits 8..0: members 0x084 give 0x280, and member 0x200 alone gives 0x200.
- R9: When the flag of an enabled class falls, one report with that class's code, detail 0, payload 0 and status 0xAA is produced.
- R10: Every report carries status 0xAA, except a rising report in which a member line beyond the class's defined width is active. Such a report carries status 0xEE with detail 0 and payload 0. Class widths by code bit are: 1:6, 3:3, 6:5, 7..12:10, 14:6, all others 1.
- R11: A rising report with status 0xAA carries that class's 32-bit payload input as sampled on the reporting edge.
- R12: While `rst` is high, `rpt_valid` is 0 and the report history is cleared. A class that is still active after the reset is reported again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (report logic only) |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| err_members | input | 190 | Member lines, 10 per class, class k at bits [10k+9:10k] |
| err_aux | input | 608 | Payload words, 32 per class, class k at bits [32k+31:32k] |
| rpt_valid | output | 1 | One-cycle report strobe |
| rpt_code | output | 32 | One-hot class code |
| rpt_detail | output | 10 | Priority-encoded detail |
| rpt_aux | output | 32 | Payload word |
| rpt_status | output | 8 | 0xAA decoded, 0xEE undecodable |

## Verification
Some properties hold on every cycle and are checked continuously: the code is one-hot whenever the strobe is high and zero otherwise, and a cleared global enable silences the next cycle. A report always belongs to a class that was enabled, the status is one of the two legal values, an undecodable report has zero detail and payload, and link-receiver detail keeps its fatal bit. The register hold across cycles without a matching write is also checked continuously. Only the scenarios can show the ordering of simultaneous classes, the absence of repeat reports while a flag stays high, removal reports, the survival of the register across reset and the re-reporting of errors still active after reset.

// File: rtl/em_pkg.sv
package em_pkg;
  localparam int NUM_CLASSES = 19;
  localparam int DETAIL_W    = 10;
  localparam int AUX_W       = 32;
  localparam int REG_W       = 32;
  localparam int ADDR_W      = 8;
  localparam int STATUS_W    = 8;
  localparam int IDX_W       = $clog2(NUM_CLASSES);
  localparam int EN_W        = NUM_CLASSES + 1;

  localparam logic [STATUS_W-1:0] ST_DECODED = 8'hAA;
  localparam logic [STATUS_W-1:0] ST_UNUSABLE = 8'hEE;

  localparam int LINK_FIRST = 7;
  localparam int LINK_LAST  = 12;

  // number of meaningful member lines in each class
  function automatic int class_width(input int k);
    case (k)
      1:       return 6;
      3:       return 3;
      6:       return 5;
      14:      return 6;
      default: return (k >= LINK_FIRST && k <= LINK_LAST) ? DETAIL_W : 1;
    endcase
  endfunction

  function automatic bit is_link_class(input int k);
    return (k >= LINK_FIRST) && (k <= LINK_LAST);
  endfunction
endpackage

// File: rtl/em_mask_reg.sv
module em_mask_reg
  import em_pkg::*;
#(
  parameter logic [ADDR_W-1:0] MASK_ADDR = 8'hF0,
  parameter logic [REG_W-1:0]  MASK_INIT = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [EN_W-1:0]   en_bits_o,
  output logic [REG_W-1:0]  rdata_o
);
  // Power-up value only; deliberately outside the reset domain.
  logic [REG_W-1:0] mask_q = MASK_INIT;
  logic             hit;

  assign hit = (addr_i == MASK_ADDR);

  always_ff @(posedge clk) begin
    if (we_i && hit) mask_q <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= hit ? mask_q : '0;
  end

  assign en_bits_o = mask_q[EN_W-1:0];

  a_r2_mask_hold: assert property (@(posedge clk) disable iff (rst)
    !(we_i && hit) |=> $stable(mask_q));
endmodule

// File: rtl/em_class_enc.sv
module em_class_enc
  import em_pkg::*;
#(
  parameter int CLASS_IDX = 0
) (
  input  logic [DETAIL_W-1:0] members_i,
  input  logic [AUX_W-1:0]    aux_i,
  output logic                flag_o,
  output logic                bad_o,
  output logic [DETAIL_W-1:0] detail_o,
  output logic [AUX_W-1:0]    aux_o
);
  localparam int WIDTH = class_width(CLASS_IDX);
  localparam bit LINK  = is_link_class(CLASS_IDX);
  localparam logic [DETAIL_W-1:0] VALID_M =
    (WIDTH >= DETAIL_W) ? '1 : DETAIL_W'((64'd1 << WIDTH) - 64'd1);
  localparam int SCAN_TOP = LINK ? DETAIL_W - 1 : WIDTH;

  logic [DETAIL_W-1:0] enc;

  always_comb begin
    enc = '0;
    for (int i = 0; i < SCAN_TOP; i++) begin
      if (members_i[i]) enc = DETAIL_W'(1) << i;
    end
    if (LINK) enc[DETAIL_W-1] = 1'b1;
  end

  assign flag_o   = |members_i;
  assign bad_o    = |(members_i & ~VALID_M);
  assign detail_o = bad_o ? '0 : enc;
  assign aux_o    = bad_o ? '0 : aux_i;
endmodule

// File: rtl/em_report_arb.sv
module em_report_arb
  import em_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_CLASSES-1:0]          enable_i,
  input  logic [NUM_CLASSES-1:0]          flags_i,
  input  logic [NUM_CLASSES-1:0]          bads_i,
  input  logic [NUM_CLASSES*DETAIL_W-1:0] details_i,
  input  logic [NUM_CLASSES*AUX_W-1:0]    auxes_i,
  output logic                            rpt_valid_o,
  output logic [REG_W-1:0]                rpt_code_o,
  output logic [DETAIL_W-1:0]             rpt_detail_o,
  output logic [AUX_W-1:0]                rpt_aux_o,
  output logic [STATUS_W-1:0]             rpt_status_o
);
  localparam logic [REG_W-1:0] LINK_CODES =
    REG_W'(((64'd1 << (LINK_LAST + 1)) - 64'd1) & ~((64'd1 << LINK_FIRST) - 64'd1));

  logic [NUM_CLASSES-1:0] seen_q, seen_d, pending;
  logic                   sel_valid;
  logic [IDX_W-1:0]       sel_idx;
  logic                   sel_flag;

  assign pending = enable_i & (flags_i ^ seen_q);

  // lowest code bit wins: scan downward, last hit is kept
  always_comb begin
    sel_valid = 1'b0;
    sel_idx   = '0;
    for (int k = NUM_CLASSES - 1; k >= 0; k--) begin
      if (pending[k]) begin
        sel_valid = 1'b1;
        sel_idx   = IDX_W'(k);
      end
    end
  end

  assign sel_flag = flags_i[sel_idx];

  always_comb begin
    seen_d = seen_q & enable_i;
    if (sel_valid) seen_d[sel_idx] = sel_flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q       <= '0;
      rpt_valid_o  <= 1'b0;
      rpt_code_o   <= '0;
      rpt_detail_o <= '0;
      rpt_aux_o    <= '0;
      rpt_status_o <= '0;
    end else begin
      seen_q       <= seen_d;
      rpt_valid_o  <= sel_valid;
      rpt_code_o   <= sel_valid ? (REG_W'(1) << sel_idx) : '0;
      rpt_detail_o <= (sel_valid && sel_flag) ? details_i[sel_idx*DETAIL_W +: DETAIL_W] : '0;
      rpt_aux_o    <= (sel_valid && sel_flag) ? auxes_i[sel_idx*AUX_W +: AUX_W] : '0;
      rpt_status_o <= !sel_valid ? '0 :
                      (sel_flag && bads_i[sel_idx]) ? ST_UNUSABLE : ST_DECODED;
    end
  end

  a_r5_code_onehot: assert property (@(posedge clk) disable iff (rst)
    rpt_valid_o |-> $countones(rpt_code_o) == 1);
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !rpt_valid_o |-> rpt_code_o == '0);
  a_r4_enabled_only: assert property (@(posedge clk) disable iff (rst)
    rpt_valid_o |-> (rpt_code_o[NUM_CLASSES-1:0] & $past(enable_i)) != '0);
  a_r10_status_legal: assert property (@(posedge clk) disable iff (rst)
    rpt_valid_o |-> (rpt_status_o == ST_DECODED || rpt_status_o == ST_UNUSABLE));
  a_r10_unusable_blank: assert property (@(posedge clk) disable iff (rst)
    (rpt_valid_o && rpt_status_o == ST_UNUSABLE) |-> (rpt_detail_o == '0 && rpt_aux_o == '0));
  a_r8_link_fatal: assert property (@(posedge clk) disable iff (rst)
    (rpt_valid_o && (rpt_code_o & LINK_CODES) != '0 && rpt_detail_o != '0)
      |-> rpt_detail_o[DETAIL_W-1]);
endmodule

// File: rtl/em_error_manager.sv
module em_error_manager
  import em_pkg::*;
#(
  parameter logic [ADDR_W-1:0] MASK_ADDR = 8'hF0,
  parameter logic [REG_W-1:0]  MASK_INIT = '0
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            reg_we,
  input  logic [ADDR_W-1:0]               reg_addr,
  input  logic [REG_W-1:0]                reg_wdata,
  output logic [REG_W-1:0]                reg_rdata,
  input  logic [NUM_CLASSES*DETAIL_W-1:0] err_members,
  input  logic [NUM_CLASSES*AUX_W-1:0]    err_aux,
  output logic                            rpt_valid,
  output logic [REG_W-1:0]                rpt_code,
  output logic [DETAIL_W-1:0]             rpt_detail,
  output logic [AUX_W-1:0]                rpt_aux,
  output logic [STATUS_W-1:0]             rpt_status
);
  logic [EN_W-1:0]                 en_bits;
  logic [NUM_CLASSES-1:0]          class_en, flags, bads;
  logic [NUM_CLASSES*DETAIL_W-1:0] details;
  logic [NUM_CLASSES*AUX_W-1:0]    auxes;

  em_mask_reg #(.MASK_ADDR(MASK_ADDR), .MASK_INIT(MASK_INIT)) u_mask (
    .clk(clk), .rst(rst), .we_i(reg_we), .addr_i(reg_addr), .wdata_i(reg_wdata),
    .en_bits_o(en_bits), .rdata_o(reg_rdata)
  );

  assign class_en = en_bits[EN_W-1:1] & {NUM_CLASSES{en_bits[0]}};

  for (genvar k = 0; k < NUM_CLASSES; k++) begin : g_cls
    em_class_enc #(.CLASS_IDX(k)) u_enc (
      .members_i(err_members[k*DETAIL_W +: DETAIL_W]),
      .aux_i    (err_aux[k*AUX_W +: AUX_W]),
      .flag_o   (flags[k]),
      .bad_o    (bads[k]),
      .detail_o (details[k*DETAIL_W +: DETAIL_W]),
      .aux_o    (auxes[k*AUX_W +: AUX_W])
    );
  end

  em_report_arb u_arb (
    .clk(clk), .rst(rst), .enable_i(class_en), .flags_i(flags), .bads_i(bads),
    .details_i(details), .auxes_i(auxes),
    .rpt_valid_o(rpt_valid), .rpt_code_o(rpt_code), .rpt_detail_o(rpt_detail),
    .rpt_aux_o(rpt_aux), .rpt_status_o(rpt_status)
  );

  a_r3_global_off: assert property (@(posedge clk) disable iff (rst)
    !en_bits[0] |=> !rpt_valid);
endmodule

// File: tb/em_error_manager_tb_top.sv
module em_error_manager_tb_top;
  import em_pkg::*;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                            rst = 1'b1;
  logic                            reg_we = 1'b0;
  logic [ADDR_W-1:0]               reg_addr = '0;
  logic [REG_W-1:0]                reg_wdata = '0;
  logic [REG_W-1:0]                reg_rdata;
  logic [NUM_CLASSES*DETAIL_W-1:0] err_members = '0;
  logic [NUM_CLASSES*AUX_W-1:0]    err_aux = '0;
  logic                            rpt_valid;
  logic [REG_W-1:0]                rpt_code;
  logic [DETAIL_W-1:0]             rpt_detail;
  logic [AUX_W-1:0]                rpt_aux;
  logic [STATUS_W-1:0]             rpt_status;

  em_error_manager dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .err_members(err_members), .err_aux(err_aux),
    .rpt_valid(rpt_valid), .rpt_code(rpt_code), .rpt_detail(rpt_detail),
    .rpt_aux(rpt_aux), .rpt_status(rpt_status)
  );

  typedef struct packed {
    logic [REG_W-1:0]    code;
    logic [DETAIL_W-1:0] detail;
    logic [AUX_W-1:0]    aux;
    logic [STATUS_W-1:0] status;
  } exp_t;

  exp_t  sb_q[$];
  int    compared = 0;
  int    mismatched = 0;
  string tag = "R12";

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: compare every report against the scoreboard head
  always @(negedge clk) begin
    if (rst) begin
      if (tag == "R12") check(rpt_valid == 1'b0, "R12", "valid during reset", 64'(rpt_valid), 0);
    end else if (rpt_valid) begin
      if (sb_q.size() == 0) begin
        check(1'b0, tag, "unexpected report code", 64'(rpt_code), 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(rpt_code == e.code, tag, "code", 64'(rpt_code), 64'(e.code));
        check(rpt_detail == e.detail, tag, "detail", 64'(rpt_detail), 64'(e.detail));
        check(rpt_aux == e.aux, tag, "aux", 64'(rpt_aux), 64'(e.aux));
        check(rpt_status == e.status, tag, "status", 64'(rpt_status), 64'(e.status));
      end
    end
  end

  task automatic slot();
    @(negedge clk); #1;
  endtask

  task automatic set_class(input int k, input logic [DETAIL_W-1:0] m, input logic [AUX_W-1:0] a);
    err_members[k*DETAIL_W +: DETAIL_W] = m;
    err_aux[k*AUX_W +: AUX_W] = a;
  endtask

  task automatic expect_rpt(input int k, input logic [DETAIL_W-1:0] d,
                            input logic [AUX_W-1:0] a, input logic [STATUS_W-1:0] s);
    sb_q.push_back('{code: REG_W'(1) << k, detail: d, aux: a, status: s});
  endtask

  task automatic drain(input string req);
    repeat (6) @(negedge clk);
    check(sb_q.size() == 0, req, "reports still outstanding", 64'(sb_q.size()), 0);
    sb_q.delete();
  endtask

  task automatic reg_write(input logic [ADDR_W-1:0] a, input logic [REG_W-1:0] d);
    slot(); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    slot(); reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [ADDR_W-1:0] a, output logic [REG_W-1:0] d);
    slot(); reg_addr = a;
    @(posedge clk); @(negedge clk);
    d = reg_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "R0", "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [REG_W-1:0] rd;
    // reset state (R12)
    repeat (4) @(negedge clk);
    check(rpt_valid == 1'b0, "R12", "valid in reset", 64'(rpt_valid), 0);
    slot(); rst = 1'b0;
    reg_read(8'hF0, rd);
    check(rd == '0, "R1", "initial config", 64'(rd), 0);

    // R3: config all-zero, errors do nothing
    tag = "R3";
    slot(); set_class(2, 10'h001, 32'h1); set_class(9, 10'h010, 32'h2);
    drain("R3");
    slot(); set_class(2, '0, '0); set_class(9, '0, '0);
    drain("R3");

    // R1: write, readback incl. upper bits, foreign address
    tag = "R1";
    reg_write(8'hF0, 32'hFFFF_FFFF);
    reg_read(8'hF0, rd);
    check(rd == 32'hFFFF_FFFF, "R1", "readback", 64'(rd), 64'hFFFF_FFFF);
    reg_write(8'hF4, 32'h0);
    reg_read(8'hF0, rd);
    check(rd == 32'hFFFF_FFFF, "R1", "foreign write ignored", 64'(rd), 64'hFFFF_FFFF);
    reg_read(8'hF4, rd);
    check(rd == '0, "R1", "foreign read", 64'(rd), 0);

    // R7 / R11: trigger-control class, L1+L2 -> L1
    tag = "R7";
    slot(); set_class(3, 10'b011, 32'hC0DE_0003); expect_rpt(3, 10'h002, 32'hC0DE_0003, 8'hAA);
    drain("R7");
    // R5: flag stays high, members change, no new report
    tag = "R5";
    slot(); set_class(3, 10'b111, 32'hC0DE_0003);
    drain("R5");
    // R9: removal
    tag = "R9";
    slot(); set_class(3, '0, '0); expect_rpt(3, '0, '0, 8'hAA);
    drain("R9");

    // R8: link-receiver class 8
    tag = "R8";
    slot(); set_class(8, 10'h084, 32'h1111_0008); expect_rpt(8, 10'h280, 32'h1111_0008, 8'hAA);
    drain("R8");
    slot(); set_class(8, '0, '0); expect_rpt(8, '0, '0, 8'hAA);
    drain("R8");
    slot(); set_class(8, 10'h200, 32'h2222_0008); expect_rpt(8, 10'h200, 32'h2222_0008, 8'hAA);
    drain("R8");
    slot(); set_class(8, '0, '0); expect_rpt(8, '0, '0, 8'hAA);
    drain("R8");

    // R10: member beyond width of class 0
    tag = "R10";
    slot(); set_class(0, 10'h008, 32'hDEAD_0000); expect_rpt(0, '0, '0, 8'hEE);
    drain("R10");
    slot(); set_class(0, '0, '0); expect_rpt(0, '0, '0, 8'hAA);
    drain("R10");

    // R6: three classes at once, lowest code first
    tag = "R6";
    slot();
    set_class(14, 10'h021, 32'hAAAA_000E);
    set_class(5, 10'h001, 32'hAAAA_0005);
    set_class(1, 10'h030, 32'hAAAA_0001);
    expect_rpt(1, 10'h020, 32'hAAAA_0001, 8'hAA);
    expect_rpt(5, 10'h001, 32'hAAAA_0005, 8'hAA);
    expect_rpt(14, 10'h020, 32'hAAAA_000E, 8'hAA);
    drain("R6");
    slot(); set_class(14, '0, '0); set_class(5, '0, '0); set_class(1, '0, '0);
    expect_rpt(1, '0, '0, 8'hAA); expect_rpt(5, '0, '0, 8'hAA); expect_rpt(14, '0, '0, 8'hAA);
    drain("R6");

    // R4: class 5 disabled via config bit 6
    tag = "R4";
    reg_write(8'hF0, 32'hFFFF_FFBF);
    slot(); set_class(5, 10'h001, 32'h5); set_class(2, 10'h001, 32'hB0B0_0002);
    expect_rpt(2, 10'h001, 32'hB0B0_0002, 8'hAA);
    drain("R4");
    slot(); set_class(5, '0, '0); set_class(2, '0, '0); expect_rpt(2, '0, '0, 8'hAA);
    drain("R4");

    // R3: global enable off while class bits set
    tag = "R3";
    reg_write(8'hF0, 32'hFFFF_FFFE);
    slot(); set_class(4, 10'h001, 32'h4);
    drain("R3");
    slot(); set_class(4, '0, '0);
    drain("R3");

    // R2 / R12: config survives reset, active error reported again
    tag = "R11";
    reg_write(8'hF0, 32'h00AB_CDEF);
    slot(); set_class(1, 10'h001, 32'h0000_00A1); expect_rpt(1, 10'h001, 32'h0000_00A1, 8'hAA);
    drain("R11");
    tag = "R12";
    slot(); rst = 1'b1;
    repeat (3) @(negedge clk);
    #1; expect_rpt(1, 10'h001, 32'h0000_00A1, 8'hAA); rst = 1'b0;
    drain("R12");
    reg_read(8'hF0, rd);
    check(rd == 32'h00AB_CDEF, "R2", "config after reset", 64'(rd), 64'h00AB_CDEF);
    tag = "R9";
    slot(); set_class(1, '0, '0); expect_rpt(1, '0, '0, 8'hAA);
    drain("R9");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule